// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-timer event unit. It compares a free-running main count against its own comparator register. When the count reaches the comparator, it sends a one-clock fire pulse to a separate interrupt unit. The main counter, the bus decoder and interrupt delivery sit outside the block. The channel receives the count value, a global enable, and write strobes for its config field and for each 32-bit half of its comparator.

Each channel works in one of two modes:

- **One-shot mode:** it fires once per arming.
- **Periodic mode:** after each expiry it re-arms itself by adding a hidden period to the comparator. The add is repeated one step per clock until the comparator is ahead of the count again. The extra steps do not raise extra events.

A 32-bit mode makes every comparison use only the low halves. In 32-bit one-shot mode, when the low half of the count is due to wrap before the match, the channel fires an extra event at the wrap and still fires later at the real match. A self-clearing set-value bit decides whether a comparator write in periodic mode also moves the comparator, or only loads the period.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, the config reads zero and fire_o is low.
- R2: Config bits: bit 0 is the timer enable, bit 1 selects periodic mode, bit 2 is set-value and bit 3 selects 32-bit mode. An armed one-shot channel (bit 1 = 0) raises fire_o for exactly one clock. The pulse comes in the cycle after a clock edge at which count minus comparator, taken as a signed number in the active width, is zero or positive. The channel then stays quiet until it is armed again.
- R3: When a periodic channel with a nonzero period expires, it fires once. It then adds the period to the comparator once per clock, without firing, until the comparator is ahead of the count.
- R4: A write to the low comparator half (cmp_wr_lo_i) loads the comparator when the channel is one-shot or set-value is 1. In periodic mode it also always loads the low half of the period. A write to the high half (cmp_wr_hi_i) loads the comparator high half when the channel is one-shot or set-value is 1; otherwise it loads only the period high half. Any accepted comparator write clears set-value. High-half writes are ignored in 32-bit mode.
- R5: A value written into the period has its most significant bit for the active width cleared. In 32-bit mode that is bit 31 of a low-half write; in 64-bit mode it is bit 31 of a high-half write.
- R6: Writing the config with bit 3 set clears the upper 32 bits of both the comparator and the period.
- R7: When a 32-bit one-shot channel is armed while the low half of the count is above the comparator and the signed difference says the match is still ahead, it fires once when the low count half wraps to a smaller value. It then fires again at the real match.
- R8: Writing enable from 0 to 1 while the global enable is high arms the channel. A write or enable change to the comparator while enabled re-arms it. Writing enable from 1 to 0 disarms it, so no event follows.
- R9: A rising global enable re-arms an enabled channel only when its comparator is not all ones. While the global enable is low, nothing fires and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CNT_W | Main count value |
| glb_en_i | input | 1 | Global enable for all channels |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 4 | Config write data (enable, periodic, set-value, 32-bit) |
| cmp_wr_lo_i | input | 1 | Write strobe for the low comparator half |
| cmp_wr_hi_i | input | 1 | Write strobe for the high comparator half |
| cmp_wdata_i | input | CNT_W/2 | Comparator write data |
| fire_o | output | 1 | One-clock expiry event |
| cfg_o | output | 4 | Current config field |
| cmp_o | output | CNT_W | Current comparator |
| per_o | output | CNT_W | Current period |

## Verification
The bench moves the count far past the comparator of a periodic channel. A design that re-fired on each catch-up step would report extra events. A design that added the period only once would leave the wrong comparator value.

The 32-bit wrap case checks two things:
- an extra event at the wrap, which a design without the wrap flag would miss;
- a second event at the real match, which a design that dropped the match after the wrap would never deliver.

Re-enabling the global switch over an all-ones comparator must stay silent. A design without that exclusion would fire at once, because any count looks past all ones. Comparator writes in periodic mode are read back, which exposes designs that move the comparator without set-value, keep the period's top bit, or leave set-value standing.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic mode32;
    logic setval;
    logic periodic;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  chan_cfg_t         cfg_wdata,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              add_per,
  output chan_cfg_t         cfg_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [CNT_W-1:0]  per_q,
  output logic              en_rise,
  output logic              en_fall,
  output logic              cmp_wr
);
  logic              wr_hi_eff;
  logic              take_cmp;
  logic [HALF_W-1:0] per_lo_val;
  logic [HALF_W-1:0] per_hi_val;
  logic [HALF_W-1:0] sum_lo;

  assign en_rise    = cfg_wr & cfg_wdata.en & ~cfg_q.en;
  assign en_fall    = cfg_wr & ~cfg_wdata.en & cfg_q.en;
  assign wr_hi_eff  = wr_hi & ~cfg_q.mode32;
  assign cmp_wr     = wr_lo | wr_hi_eff;
  assign take_cmp   = ~cfg_q.periodic | cfg_q.setval;
  // period limited to half range: clear the top bit of the active width
  assign per_lo_val = cfg_q.mode32 ? {1'b0, wdata[HALF_W-2:0]} : wdata;
  assign per_hi_val = {1'b0, wdata[HALF_W-2:0]};
  assign sum_lo     = cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q <= cfg_wdata;
      end else if (cmp_wr) begin
        cfg_q.setval <= 1'b0;
      end

      if (cfg_wr && cfg_wdata.mode32) begin
        cmp_q[CNT_W-1:HALF_W] <= '0;
        per_q[CNT_W-1:HALF_W] <= '0;
      end else if (wr_lo) begin
        if (take_cmp)       cmp_q[HALF_W-1:0] <= wdata;
        if (cfg_q.periodic) per_q[HALF_W-1:0] <= per_lo_val;
      end else if (wr_hi_eff) begin
        if (take_cmp) cmp_q[CNT_W-1:HALF_W] <= wdata;
        else          per_q[CNT_W-1:HALF_W] <= per_hi_val;
      end else if (add_per) begin
        if (cfg_q.mode32) cmp_q <= {{(CNT_W-HALF_W){1'b0}}, sum_lo};
        else              cmp_q <= cmp_q + per_q;
      end
    end
  end
endmodule

// File: rtl/evt_cmp_compare.sv
module evt_cmp_compare #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic             mode32,
  output logic             passed,
  output logic             wrap_ahead,
  output logic             wrap_cross
);
  logic [CNT_W-1:0]  diff_full;
  logic [HALF_W-1:0] diff_lo;
  logic [HALF_W-1:0] prev_lo;
  logic              prev_vld;

  assign diff_full  = count - cmp;
  assign diff_lo    = count[HALF_W-1:0] - cmp[HALF_W-1:0];
  // reached or passed: signed difference not negative in the active width
  assign passed     = mode32 ? ~diff_lo[HALF_W-1] : ~diff_full[CNT_W-1];
  // match lies beyond the next wrap of the low half
  assign wrap_ahead = mode32 & (cmp[HALF_W-1:0] < count[HALF_W-1:0]) & diff_lo[HALF_W-1];
  assign wrap_cross = prev_vld & (count[HALF_W-1:0] < prev_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lo  <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev_lo  <= count[HALF_W-1:0];
      prev_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_cmp_ctrl.sv
module evt_cmp_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic glb_en,
  input  logic en,
  input  logic periodic,
  input  logic per_nz,
  input  logic cmp_ones,
  input  logic passed,
  input  logic wrap_ahead,
  input  logic wrap_cross,
  input  logic en_rise,
  input  logic en_fall,
  input  logic cmp_wr,
  output logic fire,
  output logic add_per
);
  logic glb_q, armed_q, arm_req_q, wrap_pend_q, catch_q;
  logic glb_rise, glb_fall, disarm, arm_evt, live, hit_wrap, hit_match, reload;

  assign glb_rise  = glb_en & ~glb_q;
  assign glb_fall  = ~glb_en & glb_q;
  assign disarm    = en_fall | glb_fall;
  assign arm_evt   = (en_rise & glb_en) | (cmp_wr & glb_en & en) |
                     (glb_rise & en & ~cmp_ones);
  assign live      = armed_q & en & glb_en & ~disarm & ~arm_evt & ~arm_req_q;
  assign hit_wrap  = live & ~catch_q & wrap_pend_q & wrap_cross;
  assign hit_match = live & ~catch_q & ~wrap_pend_q & passed;
  assign reload    = periodic & per_nz;
  assign add_per   = (live & catch_q & passed & per_nz) | (hit_match & reload);

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q       <= 1'b0;
      armed_q     <= 1'b0;
      arm_req_q   <= 1'b0;
      wrap_pend_q <= 1'b0;
      catch_q     <= 1'b0;
      fire        <= 1'b0;
    end else begin
      glb_q <= glb_en;
      fire  <= hit_wrap | hit_match;
      if (disarm) begin
        armed_q     <= 1'b0;
        arm_req_q   <= 1'b0;
        wrap_pend_q <= 1'b0;
        catch_q     <= 1'b0;
      end else if (arm_evt) begin
        armed_q     <= 1'b0;
        arm_req_q   <= 1'b1;
        wrap_pend_q <= 1'b0;
        catch_q     <= 1'b0;
      end else if (arm_req_q) begin
        arm_req_q   <= 1'b0;
        armed_q     <= 1'b1;
        wrap_pend_q <= wrap_ahead & ~periodic;
      end else if (live) begin
        if (catch_q) begin
          if (!(passed && per_nz)) catch_q <= 1'b0;
        end else if (hit_wrap) begin
          wrap_pend_q <= 1'b0;
        end else if (hit_match) begin
          if (reload) catch_q <= 1'b1;
          else        armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              glb_en_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cmp_wr_lo_i,
  input  logic              cmp_wr_hi_i,
  input  logic [HALF_W-1:0] cmp_wdata_i,
  output logic              fire_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  per_o
);
  chan_cfg_t cfg_q;
  logic en_rise, en_fall, cmp_wr, add_per;
  logic passed, wrap_ahead, wrap_cross;

  evt_cmp_regs #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr_i), .cfg_wdata(chan_cfg_t'(cfg_wdata_i)),
    .wr_lo(cmp_wr_lo_i), .wr_hi(cmp_wr_hi_i), .wdata(cmp_wdata_i),
    .add_per(add_per), .cfg_q(cfg_q), .cmp_q(cmp_o), .per_q(per_o),
    .en_rise(en_rise), .en_fall(en_fall), .cmp_wr(cmp_wr)
  );

  evt_cmp_compare #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cmp (
    .clk(clk), .rst(rst), .count(count_i), .cmp(cmp_o), .mode32(cfg_q.mode32),
    .passed(passed), .wrap_ahead(wrap_ahead), .wrap_cross(wrap_cross)
  );

  evt_cmp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .glb_en(glb_en_i), .en(cfg_q.en),
    .periodic(cfg_q.periodic), .per_nz(|per_o), .cmp_ones(&cmp_o),
    .passed(passed), .wrap_ahead(wrap_ahead), .wrap_cross(wrap_cross),
    .en_rise(en_rise), .en_fall(en_fall), .cmp_wr(cmp_wr),
    .fire(fire_o), .add_per(add_per)
  );

  assign cfg_o = cfg_q;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en_i,
  input logic             fire_o,
  input logic [3:0]       cfg_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic [CNT_W-1:0] per_o
);
  localparam int HALF_W = CNT_W / 2;

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (cmp_o == {CNT_W{1'b1}} && per_o == '0 && !fire_o && cfg_o == '0));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !cfg_o[3]) |=> !fire_o);

  a_r5_period_msb_clear: assert property (@(posedge clk) disable iff (rst)
    !per_o[CNT_W-1]);

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_o[3] |-> (cmp_o[CNT_W-1:HALF_W] == '0 && per_o[CNT_W-1:HALF_W] == '0));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_o[0]) |-> !fire_o);

  a_r9_global_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en_i) |-> !fire_o);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .glb_en_i(glb_en_i), .fire_o(fire_o),
  .cfg_o(cfg_o), .cmp_o(cmp_o), .per_o(per_o)
);

// File: tb/evt_cmp_channel_tb_top.sv
module evt_cmp_channel_tb_top;
  localparam int CNT_W = 64;
  localparam int HALF_W = CNT_W / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  count_i = '0;
  logic              glb_en_i = 1'b0;
  logic              cfg_wr_i = 1'b0;
  logic [3:0]        cfg_wdata_i = '0;
  logic              cmp_wr_lo_i = 1'b0;
  logic              cmp_wr_hi_i = 1'b0;
  logic [HALF_W-1:0] cmp_wdata_i = '0;
  logic              fire_o;
  logic [3:0]        cfg_o;
  logic [CNT_W-1:0]  cmp_o;
  logic [CNT_W-1:0]  per_o;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  evt_cmp_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .count_i(count_i), .glb_en_i(glb_en_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .cmp_wr_lo_i(cmp_wr_lo_i), .cmp_wr_hi_i(cmp_wr_hi_i), .cmp_wdata_i(cmp_wdata_i),
    .fire_o(fire_o), .cfg_o(cfg_o), .cmp_o(cmp_o), .per_o(per_o)
  );

  // monitor: each fire must match the head of the expectation queue
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (!rst && fire_o) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: fire at cycle %0d, expected none", cur_req, cyc);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          n_bad++;
          $display("FAIL %s: fire at cycle %0d, expected cycle %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic expect_fire(string tag, int ofs);
    exp_q.push_back(cyc + ofs);
    tag_q.push_back(tag);
  endtask

  task automatic drained(string tag);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected fires missing, expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic chk(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cnt(logic [CNT_W-1:0] v);
    @(negedge clk);
    count_i = v;
  endtask

  task automatic wcfg(logic [3:0] v);
    @(negedge clk);
    cfg_wdata_i = v;
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic wcmp(logic hi, logic [HALF_W-1:0] d);
    @(negedge clk);
    cmp_wdata_i = d;
    if (hi) cmp_wr_hi_i = 1'b1;
    else    cmp_wr_lo_i = 1'b1;
    @(negedge clk);
    cmp_wr_hi_i = 1'b0;
    cmp_wr_lo_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1", cmp_o, {CNT_W{1'b1}});
    chk("R1", per_o, '0);
    chk("R1", {60'd0, cfg_o}, '0);
    chk("R1", {63'd0, fire_o}, '0);

    // R2 one-shot 64-bit: fires once when count jumps past comparator
    cur_req = "R2";
    glb_en_i = 1'b1;
    wcmp(1'b1, 32'd0);
    wcmp(1'b0, 32'd1000);
    chk("R4", cmp_o, 64'd1000);
    set_cnt(64'd990);
    wcfg(4'b0001);
    idle(3);
    set_cnt(64'd1010);
    expect_fire("R2", 1);
    idle(6);
    drained("R2");

    // R8 comparator write re-arms, enable fall disarms
    cur_req = "R8";
    set_cnt(64'd4000);
    wcmp(1'b0, 32'd5000);
    idle(3);
    wcfg(4'b0000);
    set_cnt(64'd6000);
    idle(6);
    drained("R8");

    // R4 set-value routing, R3 periodic catch-up
    cur_req = "R4";
    wcfg(4'b0110);
    wcmp(1'b0, 32'd100);
    chk("R4", {60'd0, cfg_o}, 64'h2);
    wcmp(1'b0, 32'd10);
    chk("R4", cmp_o, 64'd100);
    chk("R4", per_o, 64'd10);
    cur_req = "R3";
    set_cnt(64'd50);
    wcfg(4'b0011);
    idle(3);
    set_cnt(64'd135);
    expect_fire("R3", 1);
    idle(7);
    chk("R3", cmp_o, 64'd140);
    drained("R3");
    set_cnt(64'd140);
    expect_fire("R3", 1);
    idle(4);
    chk("R3", cmp_o, 64'd150);
    drained("R3");

    // R9 global enable rise re-arms a channel with a real comparator
    cur_req = "R9";
    wcfg(4'b0000);
    wcmp(1'b0, 32'd7000);
    glb_en_i = 1'b0;
    set_cnt(64'd7100);
    wcfg(4'b0001);
    idle(3);
    drained("R9");
    @(negedge clk);
    glb_en_i = 1'b1;
    expect_fire("R9", 3);
    idle(6);
    drained("R9");
    // R9 all-ones comparator is not re-armed
    glb_en_i = 1'b0;
    wcmp(1'b0, 32'hFFFF_FFFF);
    wcmp(1'b1, 32'hFFFF_FFFF);
    chk("R9", cmp_o, {CNT_W{1'b1}});
    @(negedge clk);
    glb_en_i = 1'b1;
    set_cnt(64'd8000);
    idle(8);
    drained("R9");

    // R6 selecting 32-bit mode truncates
    cur_req = "R6";
    wcfg(4'b0000);
    wcmp(1'b1, 32'd5);
    wcmp(1'b0, 32'h10);
    chk("R6", cmp_o, 64'h5_0000_0010);
    wcfg(4'b1000);
    chk("R6", cmp_o, 64'h10);

    // R7 wrap event then real match
    cur_req = "R7";
    wcmp(1'b0, 32'h20);
    set_cnt(64'h1_FFFF_FFF0);
    wcfg(4'b1001);
    idle(3);
    drained("R7");
    set_cnt(64'h2_0000_0005);
    expect_fire("R7", 1);
    idle(3);
    set_cnt(64'h2_0000_0020);
    expect_fire("R7", 1);
    idle(6);
    drained("R7");

    // R5 period top bit cleared; R4 period-only writes and set-value clear
    cur_req = "R5";
    wcfg(4'b0000);
    wcfg(4'b1010);
    wcmp(1'b0, 32'hFFFF_FFF0);
    chk("R5", per_o, 64'h7FFF_FFF0);
    chk("R4", cmp_o, 64'h20);
    wcfg(4'b0010);
    wcmp(1'b1, 32'hFFFF_FFFF);
    chk("R5", per_o, 64'h7FFF_FFFF_7FFF_FFF0);
    chk("R4", cmp_o, 64'h20);
    wcfg(4'b0110);
    wcmp(1'b1, 32'h3);
    chk("R4", {60'd0, cfg_o}, 64'h2);
    chk("R4", cmp_o, 64'h3_0000_0020);
    chk("R4", per_o, 64'h7FFF_FFFF_7FFF_FFF0);
    idle(3);
    drained("R5");
    finish_run();
  end
endmodule